// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This unit gathers the event pulses produced by the command and data engines of an SD host controller. It latches them into two 16-bit status words. The normal word holds completion and flow events. The error word holds fault events. For each word, a status-enable register decides which events may latch. A second enable register decides which latched bits take part in the single interrupt line.

Software clears status bits by writing ones to them. A write to the reset address that has bit 8 set returns the whole unit to its idle state. The present-state word shows four busy and activity flags that come straight from the engines.

Access uses a simple register port. A write strobe carries an address and data, and the write takes effect at the clock edge. A read address is sampled at each edge, and the selected word appears on `rd_data` one cycle later. Addresses:

| Address | Word |
|---|---|
| 0 | normal status |
| 1 | error status |
| 2 | normal status enable |
| 3 | error status enable |
| 4 | normal interrupt enable |
| 5 | error interrupt enable |
| 6 | present state (read only) |
| 7 | software reset (write only) |

Top module: `sdh_irq_stat_top`

## Requirements
- R1: After the synchronous reset, addresses 0 to 5 all read zero and `irq` is low.
- R2: Only these normal status bits can latch: 0 (command done), 1 (transfer done), 2 (block gap), 3 (DMA), 4 (write ready), 5 (read ready), 8 (card interrupt) and 14 (unexpected response). Bit i of `ev_norm` feeds status bit i. All other bits below 15 always read zero.
- R3: Only these error status bits can latch: 0 (command timeout), 1 (command CRC), 2 (command end bit), 3 (command index), 4 (data timeout), 5 (data CRC), 6 (data end bit), 8 (auto-stop error) and 10 (transfer size). Bit i of `ev_err` feeds status bit i. All other bits always read zero.
- R4: An event pulse whose status-enable bit is zero does not latch. A bit that is already latched stays set when its status-enable bit is later cleared.
- R5: Writing to a status word clears each bit whose data bit is one. Bits written with zero keep their value. For example, a mask with bit 8 at zero keeps a pending card interrupt.
- R6: If an enabled event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: Normal status bit 15 reads as the OR of all latched error status bits. Writing a one to it has no effect. It drops once the error bits are cleared.
- R8: `irq` is a register. One cycle after a status change, it equals the OR, over both groups, of status AND interrupt enable. The normal group includes bit 15 under normal interrupt-enable bit 15.
- R9: A write to address 7 with data bit 8 set clears both status words and all four enable registers, and drops `irq` at the same edge. A write to address 7 with bit 8 clear changes nothing.
- R10: The present-state word carries `cmd_inhibit` in bit 0, `card_busy` in bit 1, `tx_active` in bit 8 and `rx_active` in bit 9. Its other bits are zero, and writes to address 6 have no effect.
- R11: `rd_data` shows the word at `rd_addr` as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | ADDR_W | write address |
| wr_data | input | DATA_W | write data |
| rd_addr | input | ADDR_W | read address |
| rd_data | output | DATA_W | registered read data |
| ev_norm | input | DATA_W | normal event pulses (bit 15 unused) |
| ev_err | input | DATA_W | error event pulses |
| cmd_inhibit | input | 1 | command line in use |
| card_busy | input | 1 | card signals busy |
| tx_active | input | 1 | transmit in progress |
| rx_active | input | 1 | receive in progress |
| irq | output | 1 | registered interrupt request |

## Verification
The bench builds the unit at its default 16-bit width and 3-bit address. At this size, every one of the 32 event positions can be swept one at a time with all enables open. It can also be swept with single-bit interrupt enables, and all 16 combinations of the present-state inputs can be tried. Expected status words come from the implemented-bit masks written into the requirements. The bench checks the summary bit, the clear-versus-event collision and both forms of reset write by direct comparison.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_NSTAT  = 3'd0,
    A_ESTAT  = 3'd1,
    A_NSEN   = 3'd2,
    A_ESEN   = 3'd3,
    A_NIEN   = 3'd4,
    A_EIEN   = 3'd5,
    A_PSTATE = 3'd6,
    A_SWRST  = 3'd7
  } reg_addr_e;

  // latchable positions of each group
  localparam logic [REG_W-1:0] NORM_IMPL = 16'h413F;
  localparam logic [REG_W-1:0] ERR_IMPL  = 16'h057F;

  localparam int SUMMARY_BIT = 15;
  localparam int SWRST_BIT   = 8;
  localparam int PS_INHIBIT  = 0;
  localparam int PS_BUSY     = 1;
  localparam int PS_TX       = 8;
  localparam int PS_RX       = 9;
endpackage

// File: rtl/sdh_stat_bank.sv
module sdh_stat_bank #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         soft_rst,
  input  logic         wr_stat,
  input  logic         wr_se,
  input  logic         wr_ie,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] ev,
  output logic [W-1:0] stat,
  output logic [W-1:0] se,
  output logic [W-1:0] ie
);
  logic [W-1:0] stat_d;

  // per bit: an enabled event sets, a written one clears, setting wins
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_live
      assign stat_d[i] = (ev[i] & se[i]) | (stat[i] & ~(wr_stat & wdata[i]));
    end else begin : g_tied
      assign stat_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      stat <= '0;
      se   <= '0;
      ie   <= '0;
    end else begin
      stat <= stat_d;
      if (wr_se) se <= wdata;
      if (wr_ie) ie <= wdata;
    end
  end
endmodule

// File: rtl/sdh_irq_merge.sv
module sdh_irq_merge #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         soft_rst,
  input  logic [W-1:0] n_view,
  input  logic [W-1:0] n_ie,
  input  logic [W-1:0] e_stat,
  input  logic [W-1:0] e_ie,
  output logic         irq
);
  logic pending;

  assign pending = (|(n_view & n_ie)) | (|(e_stat & e_ie));

  always_ff @(posedge clk) begin
    if (rst || soft_rst) irq <= 1'b0;
    else                 irq <= pending;
  end
endmodule

// File: rtl/sdh_irq_stat_top.sv
module sdh_irq_stat_top
  import sdh_irq_pkg::*;
#(
  parameter int DATA_W = sdh_irq_pkg::REG_W,
  parameter int ADDR_W = sdh_irq_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] ev_norm,
  input  logic [DATA_W-1:0] ev_err,
  input  logic              cmd_inhibit,
  input  logic              card_busy,
  input  logic              tx_active,
  input  logic              rx_active,
  output logic              irq
);
  localparam logic [DATA_W-1:0] N_MASK = DATA_W'(NORM_IMPL);
  localparam logic [DATA_W-1:0] E_MASK = DATA_W'(ERR_IMPL);

  logic              soft_rst;
  logic              wr_nstat, wr_estat, wr_nsen, wr_esen, wr_nien, wr_eien;
  logic [DATA_W-1:0] n_stat, n_se, n_ie;
  logic [DATA_W-1:0] e_stat, e_se, e_ie;
  logic [DATA_W-1:0] n_view;
  logic [DATA_W-1:0] ps_word;
  reg_addr_e         wa, ra;

  assign wa = reg_addr_e'(wr_addr);
  assign ra = reg_addr_e'(rd_addr);

  assign wr_nstat = wr_en && (wa == A_NSTAT);
  assign wr_estat = wr_en && (wa == A_ESTAT);
  assign wr_nsen  = wr_en && (wa == A_NSEN);
  assign wr_esen  = wr_en && (wa == A_ESEN);
  assign wr_nien  = wr_en && (wa == A_NIEN);
  assign wr_eien  = wr_en && (wa == A_EIEN);
  assign soft_rst = wr_en && (wa == A_SWRST) && wr_data[SWRST_BIT];

  sdh_stat_bank #(.W(DATA_W), .IMPL(N_MASK)) u_norm (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .wr_stat(wr_nstat), .wr_se(wr_nsen), .wr_ie(wr_nien),
    .wdata(wr_data), .ev(ev_norm),
    .stat(n_stat), .se(n_se), .ie(n_ie)
  );

  sdh_stat_bank #(.W(DATA_W), .IMPL(E_MASK)) u_err (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .wr_stat(wr_estat), .wr_se(wr_esen), .wr_ie(wr_eien),
    .wdata(wr_data), .ev(ev_err),
    .stat(e_stat), .se(e_se), .ie(e_ie)
  );

  always_comb begin
    n_view = n_stat;
    n_view[SUMMARY_BIT] = |e_stat;
  end

  sdh_irq_merge #(.W(DATA_W)) u_irq (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .n_view(n_view), .n_ie(n_ie), .e_stat(e_stat), .e_ie(e_ie),
    .irq(irq)
  );

  always_comb begin
    ps_word             = '0;
    ps_word[PS_INHIBIT] = cmd_inhibit;
    ps_word[PS_BUSY]    = card_busy;
    ps_word[PS_TX]      = tx_active;
    ps_word[PS_RX]      = rx_active;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (ra)
        A_NSTAT:  rd_data <= n_view;
        A_ESTAT:  rd_data <= e_stat;
        A_NSEN:   rd_data <= n_se;
        A_ESEN:   rd_data <= e_se;
        A_NIEN:   rd_data <= n_ie;
        A_EIEN:   rd_data <= e_ie;
        A_PSTATE: rd_data <= ps_word;
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sdh_irq_stat_chk.sv
module sdh_irq_stat_chk
  import sdh_irq_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         soft_rst,
  input logic [W-1:0] ev_norm,
  input logic [W-1:0] ev_err,
  input logic [W-1:0] n_stat,
  input logic [W-1:0] e_stat,
  input logic [W-1:0] n_se,
  input logic [W-1:0] e_se,
  input logic [W-1:0] n_ie,
  input logic [W-1:0] e_ie,
  input logic [W-1:0] n_view,
  input logic         irq
);
  localparam logic [W-1:0] N_MASK = W'(NORM_IMPL);
  localparam logic [W-1:0] E_MASK = W'(ERR_IMPL);

  // R2: no unimplemented normal bit ever latches
  p_norm_unimpl_r2: assert property (@(posedge clk) disable iff (rst)
    (n_stat & ~N_MASK) == '0);

  // R3: no unimplemented error bit ever latches
  p_err_unimpl_r3: assert property (@(posedge clk) disable iff (rst)
    (e_stat & ~E_MASK) == '0);

  // R4: a newly set bit must have been enabled in the prior cycle
  p_gate_err_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (e_stat & ~$past(e_stat) & ~$past(e_se)) == '0);

  p_gate_norm_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (n_stat & ~$past(n_stat) & ~$past(n_se)) == '0);

  // R6: an enabled event is never lost, even against a clear
  p_event_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(soft_rst)) |->
      (($past(ev_err & e_se) & E_MASK & ~e_stat) == '0) &&
      (($past(ev_norm & n_se) & N_MASK & ~n_stat) == '0));

  // R8: interrupt follows status and enable by one cycle
  p_irq_follow_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(soft_rst)) |->
      irq == $past((|(n_view & n_ie)) | (|(e_stat & e_ie))));

  // R9: software reset empties every register and the line
  p_swrst_r9: assert property (@(posedge clk) disable iff (rst)
    $past(soft_rst) |-> (n_stat == '0) && (e_stat == '0) && (n_se == '0) &&
      (e_se == '0) && (n_ie == '0) && (e_ie == '0) && !irq);
endmodule

bind sdh_irq_stat_top sdh_irq_stat_chk #(.W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .soft_rst(soft_rst),
  .ev_norm(ev_norm), .ev_err(ev_err),
  .n_stat(n_stat), .e_stat(e_stat), .n_se(n_se), .e_se(e_se),
  .n_ie(n_ie), .e_ie(e_ie), .n_view(n_view), .irq(irq)
);

// File: tb/sdh_irq_stat_top_tb_top.sv
module sdh_irq_stat_top_tb_top;
  localparam logic [15:0] NMASK = 16'h413F;
  localparam logic [15:0] EMASK = 16'h057F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [15:0] ev_norm = '0;
  logic [15:0] ev_err = '0;
  logic        cmd_inhibit = 1'b0, card_busy = 1'b0, tx_active = 1'b0, rx_active = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] v;

  always #2 clk = ~clk;

  sdh_irq_stat_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ev_norm(ev_norm), .ev_err(ev_err),
    .cmd_inhibit(cmd_inhibit), .card_busy(card_busy), .tx_active(tx_active),
    .rx_active(rx_active), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); rd_addr = a;
    @(posedge clk); @(negedge clk); d = rd_data;
  endtask

  task automatic pulse(input logic [15:0] n, input logic [15:0] e);
    @(negedge clk); ev_norm = n; ev_err = e;
    @(posedge clk); @(negedge clk); ev_norm = '0; ev_err = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R1 reset word", v, 16'h0000);
    end
    check("R1 irq low", {15'b0, irq}, 16'h0000);

    // R2 normal bit sweep, R11 read of enable word
    wr(3'd2, 16'hFFFF); wr(3'd3, 16'hFFFF);
    rd(3'd2, v); check("R11 nsen readback", v, 16'hFFFF);
    for (int i = 0; i < 16; i++) begin
      pulse(16'(1) << i, 16'h0000);
      rd(3'd0, v);
      check("R2 normal latch", v, (16'(1) << i) & NMASK);
      wr(3'd0, 16'hFFFF);
    end

    // R3 error sweep, R7 summary follows
    for (int i = 0; i < 16; i++) begin
      pulse(16'h0000, 16'(1) << i);
      rd(3'd1, v);
      check("R3 error latch", v, (16'(1) << i) & EMASK);
      rd(3'd0, v);
      check("R7 summary set", v, (((16'(1) << i) & EMASK) != 0) ? 16'h8000 : 16'h0000);
      wr(3'd1, 16'hFFFF);
      rd(3'd0, v);
      check("R7 summary drop", v, 16'h0000);
    end

    // R4 gating
    wr(3'd2, 16'h0000); wr(3'd3, 16'h0000);
    pulse(16'hFFFF, 16'hFFFF);
    rd(3'd0, v); check("R4 normal blocked", v, 16'h0000);
    rd(3'd1, v); check("R4 error blocked", v, 16'h0000);
    wr(3'd2, 16'h0008);
    pulse(16'hFFFF, 16'h0000);
    rd(3'd0, v); check("R4 only enabled", v, 16'h0008);
    wr(3'd2, 16'h0000);
    rd(3'd0, v); check("R4 stays latched", v, 16'h0008);
    wr(3'd0, 16'hFFFF);

    // R5 write-one-to-clear keeps card interrupt
    wr(3'd2, 16'hFFFF);
    pulse(16'h0103, 16'h0000);
    wr(3'd0, 16'hFEFF);
    rd(3'd0, v); check("R5 card int kept", v, 16'h0100);
    wr(3'd0, 16'h0100);
    rd(3'd0, v); check("R5 cleared", v, 16'h0000);

    // R6 event beats clear
    pulse(16'h0002, 16'h0000);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h0002; ev_norm = 16'h0002;
    @(posedge clk); @(negedge clk); wr_en = 1'b0; ev_norm = '0;
    rd(3'd0, v); check("R6 event wins", v, 16'h0002);
    wr(3'd0, 16'h0002);

    // R7 writing bit 15 does not clear summary
    wr(3'd3, 16'hFFFF);
    pulse(16'h0000, 16'h0010);
    wr(3'd0, 16'h8000);
    rd(3'd0, v); check("R7 write ignored", v, 16'h8000);
    wr(3'd1, 16'hFFFF);
    rd(3'd0, v); check("R7 drop after clear", v, 16'h0000);

    // R8 interrupt per normal bit, one cycle late
    for (int i = 0; i < 15; i++) begin
      if (NMASK[i]) begin
        wr(3'd4, 16'(1) << i);
        @(negedge clk); ev_norm = 16'(1) << i;
        @(posedge clk); @(negedge clk); ev_norm = '0;
        check("R8 irq registered", {15'b0, irq}, 16'h0000);
        @(posedge clk); @(negedge clk);
        check("R8 irq normal", {15'b0, irq}, 16'h0001);
        wr(3'd0, 16'hFFFF);
        @(negedge clk);
        check("R8 irq clears", {15'b0, irq}, 16'h0000);
      end
    end
    wr(3'd4, 16'h0001);
    pulse(16'h0002, 16'h0000);
    @(negedge clk);
    check("R8 masked no irq", {15'b0, irq}, 16'h0000);
    wr(3'd0, 16'hFFFF);
    wr(3'd4, 16'h0000);
    for (int i = 0; i < 16; i++) begin
      if (EMASK[i]) begin
        wr(3'd5, 16'(1) << i);
        pulse(16'h0000, 16'(1) << i);
        @(negedge clk);
        check("R8 irq error", {15'b0, irq}, 16'h0001);
        wr(3'd1, 16'hFFFF);
      end
    end
    wr(3'd5, 16'h0000);
    wr(3'd4, 16'h8000);
    pulse(16'h0000, 16'h0400);
    @(negedge clk);
    check("R8 irq via summary", {15'b0, irq}, 16'h0001);

    // R9 software reset
    wr(3'd7, 16'h00FF);
    rd(3'd4, v); check("R9 no-op keeps ie", v, 16'h8000);
    rd(3'd1, v); check("R9 no-op keeps stat", v, 16'h0400);
    wr(3'd7, 16'h0100);
    check("R9 irq dropped", {15'b0, irq}, 16'h0000);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R9 word cleared", v, 16'h0000);
    end

    // R10 present state
    wr(3'd6, 16'hFFFF);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      cmd_inhibit = c[0]; card_busy = c[1]; tx_active = c[2]; rx_active = c[3];
      rd(3'd6, v);
      check("R10 present state", v,
            {6'b0, c[3] ? 1'b1 : 1'b0, c[2] ? 1'b1 : 1'b0, 6'b0,
             c[1] ? 1'b1 : 1'b0, c[0] ? 1'b1 : 1'b0});
    end

    finish_run();
  end
endmodule